// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It keeps three per-line registers (pending requests, a mask and an in-service set), plus a trigger-mode register that makes each line either edge or level sensitive. From these it decides whether a single interrupt output should be raised, and it reports which line would be serviced next.

Priority is circular. A three-bit rotation offset names the line that currently ranks highest, and the rest follow in ascending order with wrap-around. A pending, unmasked request interrupts only if it outranks every line already in service. Two mode bits change which in-service lines count: one drops masked lines, and one drops the cascade line on a master.

The surrounding logic drives single-cycle command pulses: acknowledge with a line number, end-of-interrupt (non-specific or specific, each with an optional rotate), and set-priority. It also holds static mode bits for automatic end-of-interrupt and rotation on that automatic end. Bus decoding and vector formation belong to the surrounding logic.

Top module: `irq_resolver`

## Requirements
- R1: While reset is low and on release, the mask register is all ones, and the request, in-service, last-level, trigger-mode (0 = edge) and offset registers are zero, so `intOut` and `winValid` are 0 and `winLine` is 0. A pulse on `maskWe` or `trigWe` loads the register from its data input at that clock edge.
- R2: Line L has priority index (L - offset) mod 8, and index 0 ranks highest. `winValid` is 1 when any bit of (request AND NOT mask) is set. `winLine` is the line of the lowest-index such bit, and it is 0 when there is none.
- R3: An edge line (trigger bit 0) sets its request bit when `reqIn` is sampled 1 after being sampled 0 on the previous edge, and it keeps the bit after the input falls. A level line (trigger bit 1) has a request bit equal to `reqIn` as sampled at the previous clock edge.
- R4: `intOut` is 1 only when the winning index is strictly smaller than the lowest index among the counted in-service bits. It follows registered state, so it changes right after the clock edge that updates that state.
- R5: Without automatic end-of-interrupt, an acknowledge sets the in-service bit of `ackLine`. It clears that line's request bit only for an edge line. A level line's request stays set.
- R6: With `autoEoi` set, an acknowledge sets no in-service bit. If `rotateAutoEoi` is also set, the offset becomes (`ackLine` + 1) mod 8.
- R7: A non-specific end-of-interrupt clears the in-service bit of highest priority, judged over the full in-service set. Its rotate form also sets the offset to (that line + 1) mod 8. A specific end-of-interrupt clears the bit of `eoiLine`, and its rotate form sets the offset to (`eoiLine` + 1) mod 8.
- R8: A set-priority pulse sets the offset to (`setPrioLine` + 1) mod 8.
- R9: With `specialMask` set, in-service lines whose mask bit is 1 are left out when the current priority is found.
- R10: With both `specialNested` and `isMaster` set, in-service bit 2 (the cascade line) is left out when the current priority is found.
- R11: When an acknowledge of an edge line falls in the same cycle as a fresh rising edge on that line, the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 8 | Raw request level per line |
| maskWe | input | 1 | Load the mask register |
| maskWd | input | 8 | New mask (1 = masked) |
| trigWe | input | 1 | Load the trigger-mode register |
| trigWd | input | 8 | New trigger modes (1 = level) |
| ackValid | input | 1 | Acknowledge pulse |
| ackLine | input | 3 | Line being acknowledged |
| autoEoi | input | 1 | Automatic end-of-interrupt mode |
| rotateAutoEoi | input | 1 | Rotate on automatic end-of-interrupt |
| eoiValid | input | 1 | End-of-interrupt pulse |
| eoiSpecific | input | 1 | End-of-interrupt targets `eoiLine` |
| eoiRotate | input | 1 | End-of-interrupt also rotates priority |
| eoiLine | input | 3 | Line for a specific end-of-interrupt |
| setPrioValid | input | 1 | Set-priority pulse |
| setPrioLine | input | 3 | Line that becomes lowest priority |
| specialMask | input | 1 | Masked lines drop out of the in-service count |
| specialNested | input | 1 | Cascade line drops out of the in-service count |
| isMaster | input | 1 | Block acts as the master of a cascade |
| intOut | output | 1 | Interrupt request to the processor |
| winValid | output | 1 | An unmasked request is pending |
| winLine | output | 3 | Line of the winning request |

## Verification
Two functions can fall in the same cycle: an acknowledge that clears an edge line's request, and a fresh rising edge that sets it again. The bench first lowers the line for one cycle while the request is still held. It then raises the line in the very cycle that carries the acknowledge pulse. It judges the outcome from `winValid` and `winLine` once the in-service bit blocks the interrupt, and it compares against the same acknowledge issued while the input stays high, where the request must vanish.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int IW    = LW + 1;

  // Strobes from the control decoder to the register datapath.
  typedef struct packed {
    logic [LINES-1:0] isrSet;   // in-service bits to set
    logic [LINES-1:0] isrClr;   // in-service bits to clear
    logic [LINES-1:0] irrAck;   // request bits acknowledged (edge lines only clear)
    logic             offLoad;  // load a new rotation offset
    logic [LW-1:0]    offVal;
  } strobe_t;

  // Lowest priority index whose rotated line is set in vec; LINES if none.
  function automatic logic [IW-1:0] prioIdx(logic [LINES-1:0] vec, logic [LW-1:0] off);
    logic [IW-1:0] res;
    res = IW'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      if (vec[LW'(k) + off]) res = IW'(k);
    end
    return res;
  endfunction

  function automatic logic [LW-1:0] idxLine(logic [IW-1:0] idx, logic [LW-1:0] off);
    return idx[LW-1:0] + off;
  endfunction

endpackage

// File: rtl/irq_res_ctrl.sv
module irq_res_ctrl
  import irq_res_pkg::*;
(
  input  logic          ackValid,
  input  logic [LW-1:0] ackLine,
  input  logic          autoEoi,
  input  logic          rotateAutoEoi,
  input  logic          eoiValid,
  input  logic          eoiSpecific,
  input  logic          eoiRotate,
  input  logic [LW-1:0] eoiLine,
  input  logic          setPrioValid,
  input  logic [LW-1:0] setPrioLine,
  input  logic          isrTopValid,
  input  logic [LW-1:0] isrTopLine,
  output strobe_t       st
);

  always_comb begin
    st = '0;

    // Acknowledge: request clear offered for every line, datapath keeps level lines.
    if (ackValid) begin
      st.irrAck[ackLine] = 1'b1;
      if (!autoEoi) st.isrSet[ackLine] = 1'b1;
    end

    // End of interrupt.
    if (eoiValid) begin
      if (eoiSpecific)      st.isrClr[eoiLine]    = 1'b1;
      else if (isrTopValid) st.isrClr[isrTopLine] = 1'b1;
    end

    // Offset sources, lowest precedence first.
    if (setPrioValid) begin
      st.offLoad = 1'b1;
      st.offVal  = setPrioLine + LW'(1);
    end
    if (eoiValid && eoiRotate) begin
      if (eoiSpecific) begin
        st.offLoad = 1'b1;
        st.offVal  = eoiLine + LW'(1);
      end else if (isrTopValid) begin
        st.offLoad = 1'b1;
        st.offVal  = isrTopLine + LW'(1);
      end
    end
    if (ackValid && autoEoi && rotateAutoEoi) begin
      st.offLoad = 1'b1;
      st.offVal  = ackLine + LW'(1);
    end
  end

endmodule

// File: rtl/irq_res_dpath.sv
module irq_res_dpath
  import irq_res_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [LINES-1:0] reqIn,
  input  logic             maskWe,
  input  logic [LINES-1:0] maskWd,
  input  logic             trigWe,
  input  logic [LINES-1:0] trigWd,
  input  logic             specialMask,
  input  logic             specialNested,
  input  logic             isMaster,
  output logic             intOut,
  output logic             winValid,
  output logic [LW-1:0]    winLine,
  output logic             isrTopValid,
  output logic [LW-1:0]    isrTopLine
);

  logic [LINES-1:0] irr, isr, imr, trig, lastLvl;
  logic [LW-1:0]    offset;
  logic [LINES-1:0] irrNext, rise, isrEff, cand;
  logic [IW-1:0]    candIdx, curIdx, topIdx;

  // Per-line request capture and in-service filtering.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign rise[g]    = reqIn[g] & ~lastLvl[g];
    assign irrNext[g] = trig[g] ? reqIn[g] : (rise[g] | (irr[g] & ~st.irrAck[g]));
    assign isrEff[g]  = isr[g]
                      & ~(specialMask & imr[g])
                      & ~(specialNested & isMaster & (g == CASCADE_LINE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr     <= '0;
      isr     <= '0;
      imr     <= '1;
      trig    <= '0;
      lastLvl <= '0;
      offset  <= '0;
    end else begin
      irr     <= irrNext;
      isr     <= (isr & ~st.isrClr) | st.isrSet;
      lastLvl <= reqIn;
      if (maskWe)     imr    <= maskWd;
      if (trigWe)     trig   <= trigWd;
      if (st.offLoad) offset <= st.offVal;
    end
  end

  always_comb begin
    cand        = irr & ~imr;
    candIdx     = prioIdx(cand, offset);
    curIdx      = prioIdx(isrEff, offset);
    topIdx      = prioIdx(isr, offset);
    winValid    = ~candIdx[LW];
    winLine     = winValid ? idxLine(candIdx, offset) : '0;
    intOut      = candIdx < curIdx;
    isrTopValid = ~topIdx[LW];
    isrTopLine  = idxLine(topIdx, offset);
  end

  // R4: an interrupt always has a pending winner behind it.
  a_r4_int_has_winner: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> winValid);

  // R3: level lines mirror the sampled input of the previous edge.
  a_r3_level_follows: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((irr & $past(trig)) == $past(reqIn & trig)));

  // R5: an acknowledged edge line without a fresh edge loses its request.
  a_r5_edge_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (|(st.irrAck & ~trig & ~rise)) |=> ((irr & $past(st.irrAck & ~trig & ~rise)) == '0));

  // R6: no in-service bit rises without a set strobe.
  a_r6_isr_only_on_set: assert property (@(posedge clk) disable iff (!rstN)
    (st.isrSet == '0) |=> ((isr & ~$past(isr)) == '0));

  // R7: at most one in-service bit is cleared per cycle.
  a_r7_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.isrClr));

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqIn,
  input  logic             maskWe,
  input  logic [LINES-1:0] maskWd,
  input  logic             trigWe,
  input  logic [LINES-1:0] trigWd,
  input  logic             ackValid,
  input  logic [LW-1:0]    ackLine,
  input  logic             autoEoi,
  input  logic             rotateAutoEoi,
  input  logic             eoiValid,
  input  logic             eoiSpecific,
  input  logic             eoiRotate,
  input  logic [LW-1:0]    eoiLine,
  input  logic             setPrioValid,
  input  logic [LW-1:0]    setPrioLine,
  input  logic             specialMask,
  input  logic             specialNested,
  input  logic             isMaster,
  output logic             intOut,
  output logic             winValid,
  output logic [LW-1:0]    winLine
);

  strobe_t       st;
  logic          isrTopValid;
  logic [LW-1:0] isrTopLine;

  irq_res_ctrl u_ctrl (
    .ackValid      (ackValid),
    .ackLine       (ackLine),
    .autoEoi       (autoEoi),
    .rotateAutoEoi (rotateAutoEoi),
    .eoiValid      (eoiValid),
    .eoiSpecific   (eoiSpecific),
    .eoiRotate     (eoiRotate),
    .eoiLine       (eoiLine),
    .setPrioValid  (setPrioValid),
    .setPrioLine   (setPrioLine),
    .isrTopValid   (isrTopValid),
    .isrTopLine    (isrTopLine),
    .st            (st)
  );

  irq_res_dpath #(.CASCADE_LINE(CASCADE_LINE)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .reqIn         (reqIn),
    .maskWe        (maskWe),
    .maskWd        (maskWd),
    .trigWe        (trigWe),
    .trigWd        (trigWd),
    .specialMask   (specialMask),
    .specialNested (specialNested),
    .isMaster      (isMaster),
    .intOut        (intOut),
    .winValid      (winValid),
    .winLine       (winLine),
    .isrTopValid   (isrTopValid),
    .isrTopLine    (isrTopLine)
  );

endmodule

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0, maskWd = '0, trigWd = '0;
  logic       maskWe = 0, trigWe = 0;
  logic       ackValid = 0, autoEoi = 0, rotateAutoEoi = 0;
  logic       eoiValid = 0, eoiSpecific = 0, eoiRotate = 0;
  logic       setPrioValid = 0, specialMask = 0, specialNested = 0, isMaster = 0;
  logic [2:0] ackLine = '0, eoiLine = '0, setPrioLine = '0;
  logic       intOut, winValid;
  logic [2:0] winLine;
  int         nTests = 0, nFail = 0;

  always #5 clk = ~clk;

  irq_resolver u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .maskWe(maskWe), .maskWd(maskWd), .trigWe(trigWe), .trigWd(trigWd),
    .ackValid(ackValid), .ackLine(ackLine),
    .autoEoi(autoEoi), .rotateAutoEoi(rotateAutoEoi),
    .eoiValid(eoiValid), .eoiSpecific(eoiSpecific), .eoiRotate(eoiRotate), .eoiLine(eoiLine),
    .setPrioValid(setPrioValid), .setPrioLine(setPrioLine),
    .specialMask(specialMask), .specialNested(specialNested), .isMaster(isMaster),
    .intOut(intOut), .winValid(winValid), .winLine(winLine)
  );

  // Inputs change at negedge; one step crosses one posedge and returns to negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic eInt, logic eVal, logic [2:0] eLine);
    nTests++;
    if (intOut !== eInt || winValid !== eVal || winLine !== eLine) begin
      nFail++;
      $display("FAIL %s: got int=%0b valid=%0b line=%0d, expected int=%0b valid=%0b line=%0d",
               tag, intOut, winValid, winLine, eInt, eVal, eLine);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reqIn = '0;
    autoEoi = 0; rotateAutoEoi = 0; specialMask = 0; specialNested = 0; isMaster = 0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic setMask(logic [7:0] v);
    maskWe = 1; maskWd = v; step(); maskWe = 0;
  endtask

  task automatic setTrig(logic [7:0] v);
    trigWe = 1; trigWd = v; step(); trigWe = 0;
  endtask

  task automatic setReq(logic [7:0] v);
    reqIn = v; step();
  endtask

  task automatic ack(logic [2:0] l);
    ackValid = 1; ackLine = l; step(); ackValid = 0;
  endtask

  task automatic eoi(logic spec, logic rot, logic [2:0] l);
    eoiValid = 1; eoiSpecific = spec; eoiRotate = rot; eoiLine = l; step();
    eoiValid = 0; eoiSpecific = 0; eoiRotate = 0;
  endtask

  task automatic setPrio(logic [2:0] l);
    setPrioValid = 1; setPrioLine = l; step(); setPrioValid = 0;
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R1: reset state, mask all ones blocks a fresh request.
    check("R1 reset outputs", 0, 0, 0);
    setReq(8'h01);
    check("R1 reset mask all ones", 0, 0, 0);

    // R2: exhaustive sweep of offset and request pairs.
    for (int off = 0; off < 8; off++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          int ia, ib, w;
          doReset();
          setMask(8'h00);
          setPrio(3'((off + 7) % 8));
          setReq(8'((1 << a) | (1 << b)));
          ia = (a - off + 8) % 8;
          ib = (b - off + 8) % 8;
          w  = (ia <= ib) ? a : b;
          check("R2 rotated winner", 1, 1, 3'(w));
        end
      end
    end

    // R4/R5/R7: in-service blocking and non-specific end of interrupt.
    doReset(); setMask(8'h00);
    setReq(8'h10);  check("R4 single request", 1, 1, 4);
    ack(4);         check("R5 edge ack clears request", 0, 0, 0);
    setReq(8'h30);  check("R4 lower request blocked", 0, 1, 5);
    setReq(8'h31);  check("R4 higher request passes", 1, 1, 0);
    ack(0);         check("R5 nested ack", 0, 1, 5);
    eoi(0, 0, 0);   check("R7 nonspecific clears top only", 0, 1, 5);
    eoi(0, 0, 0);   check("R7 nonspecific clears next", 1, 1, 5);

    // R3/R5/R7: level versus edge lines, specific end of interrupt.
    doReset(); setMask(8'h00); setTrig(8'h08);
    setReq(8'h08);  check("R3 level sets", 1, 1, 3);
    ack(3);         check("R5 level request survives ack", 0, 1, 3);
    setReq(8'h00);  check("R3 level clears on low", 0, 0, 0);
    setReq(8'h40);  check("R3 edge sets", 0, 1, 6);
    setReq(8'h00);  check("R3 edge held after fall", 0, 1, 6);
    eoi(1, 0, 3);   check("R7 specific clears line 3", 1, 1, 6);

    // R6: automatic end of interrupt and rotation on it.
    doReset(); setMask(8'h00); autoEoi = 1;
    setReq(8'h04);  check("R6 request line 2", 1, 1, 2);
    ack(2);         check("R6 auto ack clears request", 0, 0, 0);
    setReq(8'h24);  check("R6 no in-service bit left", 1, 1, 5);
    rotateAutoEoi = 1;
    ack(5);         check("R6 rotate ack", 0, 0, 0);
    setReq(8'h00);
    setReq(8'hA0);  check("R6 offset is 6 after rotate", 1, 1, 7);

    // R8/R7: set priority and rotating end of interrupt.
    doReset(); setMask(8'h00);
    setPrio(3);
    setReq(8'h0A);  check("R8 offset 4", 1, 1, 1);
    eoi(1, 1, 1);   check("R7 specific rotate offset 2", 1, 1, 3);
    ack(3);         check("R7 setup in-service 3", 0, 1, 1);
    eoi(0, 1, 0);   check("R7 nonspecific rotate clears 3", 1, 1, 1);
    setReq(8'h02);
    setReq(8'h0A);  check("R7 nonspecific rotate offset 4", 1, 1, 1);

    // R9: special mask.
    doReset(); setMask(8'h00);
    setReq(8'h02); ack(1);
    setReq(8'h22);  check("R9 blocked by in-service 1", 0, 1, 5);
    setMask(8'h02); check("R9 masked in-service still counts", 0, 1, 5);
    specialMask = 1; step();
    check("R9 special mask ignores masked in-service", 1, 1, 5);
    specialMask = 0; step();
    check("R9 special mask off again", 0, 1, 5);

    // R10: special fully nested on master.
    doReset(); setMask(8'h00); isMaster = 1;
    setReq(8'h04); ack(2);
    setReq(8'h00); setReq(8'h04);
    check("R10 same line blocked", 0, 1, 2);
    specialNested = 1; step();
    check("R10 cascade bit ignored", 1, 1, 2);
    isMaster = 0; step();
    check("R10 not master counts cascade bit", 0, 1, 2);

    // R11: acknowledge and fresh edge in one cycle.
    doReset(); setMask(8'h00);
    setReq(8'h01);  check("R11 setup", 1, 1, 0);
    setReq(8'h00);  check("R11 held after fall", 1, 1, 0);
    ackValid = 1; ackLine = 0; reqIn = 8'h01; step(); ackValid = 0;
    check("R11 fresh edge survives ack", 0, 1, 0);
    eoi(0, 0, 0);   check("R11 after eoi", 1, 1, 0);
    ack(0);         check("R11 ack without edge clears", 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule